// File: doc/BRIEF.md
# Chained DMA Descriptor Loader

This block is the sequencing core of one DMA channel that works through a linked list of transfer control blocks (TCBs) kept in on-chip memory. Software programs a two-bit control register (DMA enable, chain enable) and then writes the chain pointer. The channel reads each four-word TCB through a simple one-cycle-latency memory read port and loads its parameter registers: next pointer, count, modifier and index. It then issues one address per accepted word on a valid/ready address port. After each word the index moves by the modifier and the count drops by one. When the count is used up, the channel follows the next pointer. A zero next pointer ends the chain with a one-cycle done pulse.

A mode input picks one of two start rules. In serial-port style, the chain pointer names the first TCB, and that TCB is loaded before any word moves. In SPI style, the first transfer runs from index, modifier and count values that software wrote directly. In that mode the chain pointer names the TCB of the second transfer, and the start also needs a port-enable input and freshly written parameters. A TCB load is atomic: once it starts, it runs to the end. Clearing DMA enable stops a transfer at the next word.

Top module: `dma_chain_ctrl`

## Requirements
- R1: After reset, `xfer_valid`, `mem_rd_en` and `done` are low, and both control bits and the chain pointer read as zero.
- R2: In serial mode (`spi_mode`=0), a chain starts only when the chain pointer is written with a nonzero value while both control bits are set (bit 0 DMA enable, bit 1 chain enable). A pointer write of zero starts nothing. A pointer write with either bit clear starts nothing. Setting the bits after the pointer was written starts nothing.
- R3: A TCB is four words at consecutive addresses from its base: next pointer at +0, count at +1, modifier at +2, index at +3. One read is issued per cycle, and read data returns on the cycle after its address.
- R4: During a transfer, `xfer_addr` equals the index. On each cycle with `xfer_valid` and `xfer_ready` both high, the index advances by the modifier (modulo 2^AW) and the count drops by one. The address holds while `xfer_ready` is low. The transfer ends after count words.
- R5: When a transfer ends and the next pointer is nonzero, the TCB at that address is fetched. When the next pointer is zero, `done` is high for exactly one cycle.
- R6: A TCB with count zero moves no words and goes straight to the next-pointer step.
- R7: Once a TCB fetch has begun, all four reads are issued even if DMA enable is cleared during the fetch. If the enable is clear when the load finishes, the channel goes idle without moving words or raising `done`.
- R8: Clearing DMA enable during a transfer drops `xfer_valid` from the next cycle. The channel returns to idle, moves no further words and does not raise `done`.
- R9: In SPI mode (`spi_mode`=1), the first transfer uses the directly written index, modifier and count, and its first word goes out before any TCB read. The chain pointer value names the TCB of the second transfer. A pointer value of zero gives a single transfer followed by `done`.
- R10: In SPI mode, a pointer write starts a chain only if all four conditions hold: both control bits are set, `port_en` is high, and count, modifier and index have each been written since the last SPI start. Parameter select codes are 1 count, 2 modifier, 3 index; code 0 writes nothing.
- R11: Chain pointer writes and parameter writes made while a chain is active are ignored.
- R12: `mem_rd_en` and `xfer_valid` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_mode | input | 1 | Start rule: 0 serial-port style, 1 SPI style |
| port_en | input | 1 | Port enabled; gates the SPI-style start |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 2 | Bit 0 DMA enable, bit 1 chain enable |
| cp_we | input | 1 | Chain pointer write strobe |
| cp_wdata | input | AW | Chain pointer value |
| par_we | input | 1 | Direct parameter write strobe |
| par_sel | input | 2 | 1 count, 2 modifier, 3 index, 0 none |
| par_wdata | input | AW | Direct parameter value |
| mem_rd_en | output | 1 | TCB read request |
| mem_rd_addr | output | AW | TCB read address |
| mem_rd_data | input | AW | Read data, one cycle after the request |
| xfer_valid | output | 1 | Data word address valid |
| xfer_ready | input | 1 | Word accepted when high with valid |
| xfer_addr | output | AW | Data word address |
| done | output | 1 | One-cycle pulse at the end of the chain |

## Verification
The bench targets the boundary cases where a plausible mistake changes the address stream. An index that wraps past the top of the address space would show up as a wrong word address. A modifier that acts as a negative step would reverse the stream incorrectly. A count of one must give one word, and a count of zero must give none; an off-by-one count would move one word too many or too few. A fetch that honoured a disable would show fewer than four reads. An abort that ignored the disable would keep issuing words or raise `done`. In SPI mode, a design that fetched the pointer's TCB first would emit the TCB's addresses before the directly written ones. A design that did not consume the initialisation flags would restart on a bare pointer write. A channel that accepted pointer or parameter writes while busy would jump to a foreign TCB or corrupt the address sequence.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

  // Words per transfer control block and the width of a word counter.
  localparam int unsigned TCB_WORDS = 4;
  localparam int unsigned TCB_IDX_W = $clog2(TCB_WORDS);

  // Word position inside a TCB; also the direct parameter select code.
  typedef enum logic [TCB_IDX_W-1:0] {
    SEL_NEXT  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_MOD   = 2'd2,
    SEL_INDEX = 2'd3
  } word_sel_e;

  // Control register bit positions.
  localparam int unsigned CTL_DMA_BIT   = 0;
  localparam int unsigned CTL_CHAIN_BIT = 1;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_MOVE,
    ST_LINK
  } state_e;

endpackage

// File: rtl/dma_tcb_fetch.sv
module dma_tcb_fetch
  import dma_chain_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [AW-1:0] mem_rd_data,
  output logic          ld_valid,
  output word_sel_e     ld_sel,
  output logic [AW-1:0] ld_data,
  output logic          fetch_done
);

  localparam logic [TCB_IDX_W-1:0] LAST_IDX = TCB_IDX_W'(TCB_WORDS - 1);

  logic                 issuing_q, issuing_d;
  logic [TCB_IDX_W-1:0] iss_cnt_q, iss_cnt_d;
  logic [AW-1:0]        addr_q, addr_d;
  logic                 ret_valid_q;
  logic [TCB_IDX_W-1:0] ret_idx_q;
  logic                 iss_en;

  // Issue side: one address per cycle, four in a row, never interrupted.
  always_comb begin
    issuing_d = issuing_q;
    iss_cnt_d = iss_cnt_q;
    addr_d    = addr_q;
    iss_en    = start || issuing_q;
    if (start) begin
      issuing_d = 1'b1;
      iss_cnt_d = '0;
      addr_d    = base;
    end else if (issuing_q) begin
      addr_d    = addr_q + AW'(1);
      iss_cnt_d = iss_cnt_q + TCB_IDX_W'(1);
      if (iss_cnt_q == LAST_IDX) begin
        issuing_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issuing_q   <= 1'b0;
      iss_cnt_q   <= '0;
      addr_q      <= '0;
      ret_valid_q <= 1'b0;
      ret_idx_q   <= '0;
    end else begin
      ret_valid_q <= issuing_q;
      ret_idx_q   <= iss_cnt_q;
      if (iss_en) begin
        issuing_q <= issuing_d;
        iss_cnt_q <= iss_cnt_d;
        addr_q    <= addr_d;
      end
    end
  end

  assign mem_rd_en   = issuing_q;
  assign mem_rd_addr = addr_q;

  // Return side: data arrives one cycle after its address.
  assign ld_valid   = ret_valid_q;
  assign ld_sel     = word_sel_e'(ret_idx_q);
  assign ld_data    = mem_rd_data;
  assign fetch_done = ret_valid_q && (ret_idx_q == LAST_IDX);

endmodule

// File: rtl/dma_xfer_regs.sv
module dma_xfer_regs
  import dma_chain_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  word_sel_e     wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic          step,
  output logic [AW-1:0] idx_q,
  output logic [AW-1:0] mod_q,
  output logic [CW-1:0] cnt_q,
  output logic          last_word
);

  logic          idx_en, mod_en, cnt_en;
  logic [AW-1:0] idx_d;
  logic [CW-1:0] cnt_d;

  always_comb begin
    idx_en = step || (wr_en && wr_sel == SEL_INDEX);
    mod_en = wr_en && wr_sel == SEL_MOD;
    cnt_en = step || (wr_en && wr_sel == SEL_COUNT);
    idx_d  = (wr_en && wr_sel == SEL_INDEX) ? wr_data : idx_q + mod_q;
    cnt_d  = (wr_en && wr_sel == SEL_COUNT) ? wr_data[CW-1:0] : cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      mod_q <= '0;
      cnt_q <= '0;
    end else begin
      if (idx_en) idx_q <= idx_d;
      if (mod_en) mod_q <= wr_data;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign last_word = (cnt_q == CW'(1));

endmodule

// File: rtl/dma_chain_ctrl.sv
module dma_chain_ctrl
  import dma_chain_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_mode,
  input  logic          port_en,
  input  logic          ctl_we,
  input  logic [1:0]    ctl_wdata,
  input  logic          cp_we,
  input  logic [AW-1:0] cp_wdata,
  input  logic          par_we,
  input  logic [1:0]    par_sel,
  input  logic [AW-1:0] par_wdata,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [AW-1:0] mem_rd_data,
  output logic          xfer_valid,
  input  logic          xfer_ready,
  output logic [AW-1:0] xfer_addr,
  output logic          done
);

  localparam logic [AW-1:0] NULL_PTR = '0;
  localparam int unsigned   INIT_W   = TCB_WORDS - 1;

  state_e            state_q, state_d;
  logic              dma_en_q, chain_en_q;
  logic [AW-1:0]     cp_q, cp_d;
  logic              cp_en;
  logic [INIT_W-1:0] init_q, init_d, init_set;
  logic              init_en;

  logic              idle, chain_ok, start_ser, start_spi, sw_par_we, accept;
  logic              fetch_start;
  logic [AW-1:0]     fetch_base;
  logic              ld_valid, fetch_done;
  word_sel_e         ld_sel;
  logic [AW-1:0]     ld_data;
  logic              wr_en;
  word_sel_e         wr_sel;
  logic [AW-1:0]     wr_data;
  logic [AW-1:0]     idx_q, mod_q;
  logic [CW-1:0]     cnt_q;
  logic              last_word;

  dma_tcb_fetch #(.AW(AW)) u_fetch (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (fetch_start),
    .base        (fetch_base),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .mem_rd_data (mem_rd_data),
    .ld_valid    (ld_valid),
    .ld_sel      (ld_sel),
    .ld_data     (ld_data),
    .fetch_done  (fetch_done)
  );

  dma_xfer_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .step      (accept),
    .idx_q     (idx_q),
    .mod_q     (mod_q),
    .cnt_q     (cnt_q),
    .last_word (last_word)
  );

  // Start qualification and register write steering.
  always_comb begin
    idle      = (state_q == ST_IDLE);
    chain_ok  = dma_en_q && chain_en_q;
    start_ser = idle && cp_we && !spi_mode && chain_ok && (cp_wdata != NULL_PTR);
    start_spi = idle && cp_we && spi_mode && chain_ok && port_en && (&init_q);
    sw_par_we = idle && par_we && (word_sel_e'(par_sel) != SEL_NEXT);

    // Fetched words win; software writes are only taken while idle.
    wr_en   = ld_valid ? (ld_sel != SEL_NEXT) : sw_par_we;
    wr_sel  = ld_valid ? ld_sel : word_sel_e'(par_sel);
    wr_data = ld_valid ? ld_data : par_wdata;

    cp_en = (idle && cp_we) || (ld_valid && ld_sel == SEL_NEXT);
    cp_d  = ld_valid ? ld_data : cp_wdata;

    init_set = '0;
    if (sw_par_we) begin
      init_set[par_sel - 2'd1] = 1'b1;
    end
    init_en = sw_par_we || start_spi;
    init_d  = start_spi ? '0 : (init_q | init_set);
  end

  assign xfer_valid = (state_q == ST_MOVE) && dma_en_q;
  assign xfer_addr  = idx_q;
  assign accept     = xfer_valid && xfer_ready;
  assign done       = (state_q == ST_LINK) && dma_en_q && (cp_q == NULL_PTR);

  // Next-state logic.
  always_comb begin
    state_d     = state_q;
    fetch_start = 1'b0;
    fetch_base  = cp_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_ser) begin
          state_d     = ST_FETCH;
          fetch_start = 1'b1;
          fetch_base  = cp_wdata;
        end else if (start_spi) begin
          state_d = (cnt_q == '0) ? ST_LINK : ST_MOVE;
        end
      end
      ST_FETCH: begin
        // Count was loaded two words earlier, so it is already valid here.
        if (fetch_done) begin
          if (!dma_en_q)          state_d = ST_IDLE;
          else if (cnt_q == '0)   state_d = ST_LINK;
          else                    state_d = ST_MOVE;
        end
      end
      ST_MOVE: begin
        if (!dma_en_q)                  state_d = ST_IDLE;
        else if (accept && last_word)   state_d = ST_LINK;
      end
      ST_LINK: begin
        if (!dma_en_q) begin
          state_d = ST_IDLE;
        end else if (cp_q != NULL_PTR) begin
          state_d     = ST_FETCH;
          fetch_start = 1'b1;
        end else begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      dma_en_q   <= 1'b0;
      chain_en_q <= 1'b0;
      cp_q       <= '0;
      init_q     <= '0;
    end else begin
      state_q <= state_d;
      if (ctl_we) begin
        dma_en_q   <= ctl_wdata[CTL_DMA_BIT];
        chain_en_q <= ctl_wdata[CTL_CHAIN_BIT];
      end
      if (cp_en)   cp_q   <= cp_d;
      if (init_en) init_q <= init_d;
    end
  end

endmodule

// File: rtl/dma_chain_chk.sv
module dma_chain_chk
  import dma_chain_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_rd_en,
  input logic [AW-1:0] mem_rd_addr,
  input logic          xfer_valid,
  input logic          xfer_ready,
  input logic [AW-1:0] xfer_addr,
  input logic          done,
  input state_e        state_q,
  input logic          fetch_done,
  input logic [AW-1:0] mod_q,
  input logic [CW-1:0] cnt_q
);

  // R3: back-to-back reads walk upward one word at a time.
  a_r3_reads_consecutive: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && $past(mem_rd_en)) |-> mem_rd_addr == $past(mem_rd_addr) + AW'(1));

  // R4: an accepted word that is not the last moves the address by the modifier.
  a_r4_addr_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && xfer_ready && cnt_q > CW'(1))
      |=> (!xfer_valid || xfer_addr == $past(xfer_addr) + $past(mod_q)));

  // R4: a stalled word keeps its address.
  a_r4_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_ready) |=> (!xfer_valid || $stable(xfer_addr)));

  // R5: done lasts a single cycle.
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: a started TCB load is not left before its last word.
  a_r7_fetch_atomic: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FETCH && !fetch_done) |=> state_q == ST_FETCH);

  // R8: an idle channel is silent on both ports.
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> (!xfer_valid && !mem_rd_en && !done));

  // R12: descriptor reads and word addresses never overlap.
  a_r12_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> !mem_rd_en);

endmodule

bind dma_chain_ctrl dma_chain_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mem_rd_en   (mem_rd_en),
  .mem_rd_addr (mem_rd_addr),
  .xfer_valid  (xfer_valid),
  .xfer_ready  (xfer_ready),
  .xfer_addr   (xfer_addr),
  .done        (done),
  .state_q     (state_q),
  .fetch_done  (fetch_done),
  .mod_q       (mod_q),
  .cnt_q       (cnt_q)
);

// File: tb/dma_chain_ctrl_test.sv
`timescale 1ns/1ps
module dma_chain_ctrl_test;

  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          spi_mode, port_en;
  logic          ctl_we;
  logic [1:0]    ctl_wdata;
  logic          cp_we;
  logic [AW-1:0] cp_wdata;
  logic          par_we;
  logic [1:0]    par_sel;
  logic [AW-1:0] par_wdata;
  logic          mem_rd_en;
  logic [AW-1:0] mem_rd_addr;
  logic [AW-1:0] mem_rd_data;
  logic          xfer_valid;
  logic          xfer_ready;
  logic [AW-1:0] xfer_addr;
  logic          done;

  always #2.5 clk = ~clk;

  dma_chain_ctrl #(.AW(AW), .CW(16)) uut (
    .clk(clk), .rst_n(rst_n), .spi_mode(spi_mode), .port_en(port_en),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .cp_we(cp_we), .cp_wdata(cp_wdata),
    .par_we(par_we), .par_sel(par_sel), .par_wdata(par_wdata),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_addr(xfer_addr),
    .done(done)
  );

  // Descriptor memory with one cycle of read latency.
  logic [AW-1:0] mem [64];
  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[5:0]];

  // Monitor: drives ready from a rotating pattern and logs port activity.
  logic [7:0]    rdy_pat = 8'hFF;
  logic [2:0]    ph = 3'd0;
  logic [AW-1:0] wlog [64];
  logic [AW-1:0] rlog [64];
  int nw = 0, nr = 0, nd = 0, novl = 0, nr_at_w0 = -1;
  int nchk = 0, nerr = 0;

  always @(negedge clk) begin
    xfer_ready = rdy_pat[ph];
    ph = ph + 3'd1;
    if (rst_n) begin
      if (xfer_valid && xfer_ready) begin
        if (nw == 0) nr_at_w0 = nr;
        if (nw < 64) wlog[nw] = xfer_addr;
        nw++;
      end
      if (mem_rd_en) begin
        if (nr < 64) rlog[nr] = mem_rd_addr;
        nr++;
      end
      if (done) nd++;
      if (xfer_valid && mem_rd_en) novl++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_logs();
    nw = 0; nr = 0; nd = 0; nr_at_w0 = -1; ph = 3'd0;
  endtask

  task automatic write_ctl(input logic [1:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic write_cp(input logic [AW-1:0] v);
    @(negedge clk); cp_we = 1'b1; cp_wdata = v;
    @(negedge clk); cp_we = 1'b0;
  endtask

  task automatic write_par(input logic [1:0] s, input logic [AW-1:0] v);
    @(negedge clk); par_we = 1'b1; par_sel = s; par_wdata = v;
    @(negedge clk); par_we = 1'b0;
  endtask

  task automatic put_tcb(input int base, input logic [AW-1:0] nxt, input logic [AW-1:0] cnt,
                         input logic [AW-1:0] md, input logic [AW-1:0] ix);
    mem[base]   = nxt;
    mem[base+1] = cnt;
    mem[base+2] = md;
    mem[base+3] = ix;
  endtask

  task automatic wait_done(input int maxc);
    int n0;
    n0 = nd;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      if (nd != n0) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic check_words(input string tag, input logic [AW-1:0] ix,
                             input logic [AW-1:0] md, input int cnt);
    chk(nw == cnt, tag, nw, cnt);
    for (int k = 0; k < cnt && k < 64; k++) begin
      logic [AW-1:0] e;
      e = ix + AW'(k) * md;
      chk(wlog[k] == e, tag, int'(wlog[k]), int'(e));
    end
  endtask

  // index, modifier, count, ready pattern
  localparam logic [55:0] VEC [5] = '{
    {16'h0100, 16'h0001, 16'd4, 8'hFF},
    {16'h0200, 16'h0003, 16'd5, 8'b1010_1010},
    {16'h0300, 16'hFFFF, 16'd3, 8'hFF},
    {16'hFFFE, 16'h0002, 16'd3, 8'b1100_1100},
    {16'h0040, 16'h0000, 16'd1, 8'hFF}
  };

  initial begin
    #(5 * 150000);
    nerr++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    rst_n = 1'b0; spi_mode = 1'b0; port_en = 1'b0;
    ctl_we = 1'b0; ctl_wdata = '0; cp_we = 1'b0; cp_wdata = '0;
    par_we = 1'b0; par_sel = '0; par_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: quiet after reset
    chk(!xfer_valid && !mem_rd_en && !done, "R1 reset outputs",
        {xfer_valid, mem_rd_en, done}, 0);

    // R2: pointer written before enabling does not start on enable
    clear_logs();
    put_tcb(8, 16'h0, 16'd2, 16'h1, 16'h0010);
    write_cp(16'd8);
    write_ctl(2'b11);
    repeat (10) @(negedge clk);
    chk(nr == 0 && nw == 0, "R2 enable after pointer", nr + nw, 0);

    // R2: zero pointer starts nothing; chain bit missing starts nothing
    write_cp(16'd0);
    repeat (10) @(negedge clk);
    chk(nr == 0 && nd == 0, "R2 zero pointer", nr + nd, 0);
    write_ctl(2'b01);
    write_cp(16'd8);
    repeat (10) @(negedge clk);
    chk(nr == 0, "R2 chain bit clear", nr, 0);
    write_ctl(2'b11);

    // Table walk: single-TCB chains in serial mode (R3, R4, R5)
    for (int v = 0; v < 5; v++) begin
      logic [AW-1:0] ix, md, cn;
      {ix, md, cn, rdy_pat} = VEC[v];
      put_tcb(8, 16'h0, cn, md, ix);
      clear_logs();
      write_cp(16'd8);
      wait_done(300);
      check_words("R4 vector words", ix, md, int'(cn));
      chk(nr == 4, "R3 reads per TCB", nr, 4);
      for (int k = 0; k < 4; k++) chk(rlog[k] == AW'(8 + k), "R3 read address", int'(rlog[k]), 8 + k);
      chk(nd == 1, "R5 done once", nd, 1);
    end
    rdy_pat = 8'hFF;

    // R5: two linked TCBs
    put_tcb(8, 16'd16, 16'd2, 16'h1, 16'h0010);
    put_tcb(16, 16'd0, 16'd2, 16'h2, 16'h0020);
    clear_logs();
    write_cp(16'd8);
    wait_done(300);
    chk(nw == 4 && wlog[0] == 16'h10 && wlog[1] == 16'h11 && wlog[2] == 16'h20 && wlog[3] == 16'h22,
        "R5 linked words", int'(wlog[2]), 16'h20);
    chk(nr == 8 && rlog[4] == 16'd16, "R5 second fetch", int'(rlog[4]), 16);
    chk(nd == 1, "R5 one done per chain", nd, 1);

    // R6: zero-count TCB in the middle
    put_tcb(8, 16'd24, 16'd0, 16'h1, 16'h0099);
    put_tcb(24, 16'd0, 16'd1, 16'h0, 16'h0030);
    clear_logs();
    write_cp(16'd8);
    wait_done(300);
    chk(nw == 1 && wlog[0] == 16'h30, "R6 zero count skipped", int'(wlog[0]), 16'h30);
    chk(nr == 8 && nd == 1, "R6 reads and done", nr, 8);

    // R7: disable during fetch still completes four reads
    put_tcb(8, 16'd0, 16'd3, 16'h1, 16'h0040);
    clear_logs();
    write_cp(16'd8);
    write_ctl(2'b00);
    repeat (12) @(negedge clk);
    chk(nr == 4, "R7 fetch atomic", nr, 4);
    chk(nw == 0 && nd == 0, "R7 no words after disabled load", nw + nd, 0);

    // R8: abort mid-transfer
    write_ctl(2'b11);
    put_tcb(8, 16'd0, 16'd20, 16'h1, 16'h0100);
    clear_logs();
    write_cp(16'd8);
    for (int i = 0; i < 100 && nw < 3; i++) @(negedge clk);
    write_ctl(2'b00);
    repeat (4) @(negedge clk);
    begin
      int w1;
      w1 = nw;
      repeat (8) @(negedge clk);
      chk(nw == w1 && nw < 20, "R8 words stop", nw, w1);
    end
    chk(!xfer_valid && nd == 0, "R8 no done after abort", nd, 0);
    write_ctl(2'b11);
    put_tcb(8, 16'd0, 16'd1, 16'h0, 16'h0123);
    clear_logs();
    write_cp(16'd8);
    wait_done(300);
    chk(nw == 1 && wlog[0] == 16'h0123 && nd == 1, "R8 restart after abort", int'(wlog[0]), 16'h0123);

    // R11: pointer and parameter writes while busy are ignored
    rdy_pat = 8'b1000_0001;
    put_tcb(8, 16'd0, 16'd6, 16'h1, 16'h0200);
    put_tcb(40, 16'd0, 16'd2, 16'h1, 16'h0300);
    clear_logs();
    write_cp(16'd8);
    for (int i = 0; i < 100 && nw < 1; i++) @(negedge clk);
    write_cp(16'd40);
    write_par(2'd3, 16'h0999);
    wait_done(400);
    check_words("R11 busy writes ignored", 16'h0200, 16'h1, 6);
    chk(nr == 4 && nd == 1, "R11 no extra fetch", nr, 4);
    rdy_pat = 8'hFF;

    // R9: SPI mode, first transfer from direct parameters
    spi_mode = 1'b1; port_en = 1'b1;
    put_tcb(8, 16'd0, 16'd1, 16'h0, 16'h0060);
    write_par(2'd1, 16'd2);
    write_par(2'd2, 16'h1);
    write_par(2'd3, 16'h0050);
    clear_logs();
    write_cp(16'd8);
    wait_done(300);
    chk(nw == 3 && wlog[0] == 16'h50 && wlog[1] == 16'h51 && wlog[2] == 16'h60,
        "R9 direct then TCB", int'(wlog[2]), 16'h60);
    chk(nr_at_w0 == 0 && nr == 4 && rlog[0] == 16'd8, "R9 first word before fetch", nr_at_w0, 0);
    chk(nd == 1, "R9 done", nd, 1);

    // R10: port disabled blocks the start
    port_en = 1'b0;
    write_par(2'd1, 16'd2);
    write_par(2'd2, 16'h4);
    write_par(2'd3, 16'h0070);
    clear_logs();
    write_cp(16'd0);
    repeat (10) @(negedge clk);
    chk(nw == 0 && nd == 0, "R10 port disabled", nw + nd, 0);

    // R9: zero pointer in SPI mode gives one transfer and done
    port_en = 1'b1;
    clear_logs();
    write_cp(16'd0);
    wait_done(100);
    chk(nw == 2 && wlog[0] == 16'h70 && wlog[1] == 16'h74, "R9 single transfer", int'(wlog[1]), 16'h74);
    chk(nr == 0 && nd == 1, "R9 no fetch, done", nr, 0);

    // R10: parameters consumed, bare pointer write starts nothing
    clear_logs();
    write_cp(16'd8);
    repeat (10) @(negedge clk);
    chk(nw == 0 && nr == 0, "R10 stale parameters", nw + nr, 0);

    // R12: no overlap seen over the whole run
    chk(novl == 0, "R12 read and word overlap", novl, 0);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule